// File: doc/BRIEF.md
# Masked-write GPIO register bank

This block is the register front end of a 32-pin general purpose I/O controller on a simple 32-bit memory-mapped bus. Software controls each pin's output level and direction through pairs of 16-bit registers. One register of a pair covers pins 0 to 15 and the other covers pins 16 to 31. Every write carries its own per-bit enables in the upper half-word. A driver can therefore set or clear a single pin with one store, with no read-modify-write sequence and no lock against other writers.

Pin levels pass through a synchronizer into a read-only port register. A fixed identifier register lets software tell this register layout apart from older banks that use one 32-bit register per function. Read data is registered and holds its value until the next read strobe.

Top module: `mwgpio_bank`

## Requirements
- R1: After reset, pin_out, pin_oe and bus_rdata are all zero, so every pin is an input driving low.
- R2: A write to the low output register (byte offset 0x00) sets bit k (k = 0..15) of pin_out to wdata[k] only when wdata[k+16] is 1. When wdata[k+16] is 0, that pin keeps its previous level.
- R3: The high output register sits at offset 0x04. It uses the same masked rule, so wdata[k] with enable wdata[k+16] drives pin 16+k.
- R4: The direction registers sit at 0x08 (pins 0..15) and 0x0C (pins 16..31). They use the same masked rule and drive pin_oe, where 1 means output and 0 means input.
- R5: A read of any output or direction register returns its 16 stored bits in bus_rdata[15:0] and zeros in bus_rdata[31:16].
- R6: A read at 0x70 returns the pin_in levels, with bit n giving pin n, after a two-flop synchronizer. Take pin_in changing between two clock edges. Reads strobed at the first and second edges after the change return the old level. A read strobed at the third edge returns the new level.
- R7: A read at 0x78 returns the constant 0x0101157C.
- R8: Writes to 0x70, 0x78, any other offset, or any address whose two low bits are not zero leave pin_out and pin_oe unchanged.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x70 or 0x78 returns zero. This includes addresses whose two low bits are not zero.
- R10: bus_rdata updates on the clock edge where bus_rd is high. It stays unchanged on edges without bus_rd, including edges that carry writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data: [31:16] per-bit enables, [15:0] values |
| bus_rdata | output | 32 | Registered read data, valid one clock after bus_rd |
| pin_in | input | 32 | Pin levels, asynchronous to clk |
| pin_out | output | 32 | Output level for each pin |
| pin_oe | output | 32 | Output enable for each pin, 1 = drive |

## Verification
The bench builds the bank with its default parameters: a 32-bit data path split into two 16-bit halves, an 8-bit byte address, two synchronizer stages and the standard identifier. With these values every mapped offset and both register halves can be reached. The bench can also reach misaligned and unmapped addresses inside the 256-byte window, and it can measure the exact three-edge visibility of a pin change through the synchronizer. Random stores, with random enable masks across all eight address classes, are mixed with directed single-bit set and clear cases.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
   localparam int unsigned OFS_OUT_LO = 32'h00;
   localparam int unsigned OFS_OUT_HI = 32'h04;
   localparam int unsigned OFS_DIR_LO = 32'h08;
   localparam int unsigned OFS_DIR_HI = 32'h0C;
   localparam int unsigned OFS_EXT    = 32'h70;
   localparam int unsigned OFS_ID     = 32'h78;
   localparam logic [31:0] ID_DEFAULT = 32'h0101157C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_OUT_LO,
      SEL_OUT_HI,
      SEL_DIR_LO,
      SEL_DIR_HI,
      SEL_EXT,
      SEL_ID
   } sel_e;

   function automatic sel_e decode_sel(input logic [31:0] a);
      sel_e s;
      case (a)
         OFS_OUT_LO: s = SEL_OUT_LO;
         OFS_OUT_HI: s = SEL_OUT_HI;
         OFS_DIR_LO: s = SEL_DIR_LO;
         OFS_DIR_HI: s = SEL_DIR_HI;
         OFS_EXT:    s = SEL_EXT;
         OFS_ID:     s = SEL_ID;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/mwg_mreg.sv
module mwg_mreg #(
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [2*W-1:0] wdata,
   output logic [W-1:0]   q
);
   logic [W-1:0] en;
   logic [W-1:0] val;

   assign en  = wdata[2*W-1:W];
   assign val = wdata[W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= (q & ~en) | (val & en);
   end

   // R2: bits whose enable is clear keep their value across a write
   p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q ^ $past(q)) & ~$past(wdata[2*W-1:W])) == '0);

   // R8: no write strobe, no change
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/mwg_sync.sv
module mwg_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mwg_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)
            chain[s] <= '0;
         else if (s == 0)
            chain[s] <= d;
         else
            chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mwg_rdmux.sv
module mwg_rdmux
   import mwg_pkg::*;
#(
   parameter int          HALF_W = 16,
   parameter logic [31:0] ID     = ID_DEFAULT,
   localparam int         DW     = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  sel_e              sel,
   input  logic [HALF_W-1:0] out_lo,
   input  logic [HALF_W-1:0] out_hi,
   input  logic [HALF_W-1:0] dir_lo,
   input  logic [HALF_W-1:0] dir_hi,
   input  logic [DW-1:0]     ext,
   output logic [DW-1:0]     rdata
);
   localparam logic [HALF_W-1:0] ZH = '0;

   logic [DW-1:0] nxt;

   always_comb begin
      case (sel)
         SEL_OUT_LO: nxt = {ZH, out_lo};
         SEL_OUT_HI: nxt = {ZH, out_hi};
         SEL_DIR_LO: nxt = {ZH, dir_lo};
         SEL_DIR_HI: nxt = {ZH, dir_hi};
         SEL_EXT:    nxt = ext;
         SEL_ID:     nxt = ID[DW-1:0];
         default:    nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= nxt;
   end

   p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd && (sel inside {SEL_OUT_LO, SEL_OUT_HI, SEL_DIR_LO, SEL_DIR_HI})
      |=> rdata[DW-1:HALF_W] == '0);

   p_id_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd && sel == SEL_ID |=> rdata == ID[DW-1:0]);

   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd && sel == SEL_NONE |=> rdata == '0);

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));
endmodule

// File: rtl/mwgpio_bank.sv
module mwgpio_bank
   import mwg_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          HALF_W      = 16,
   parameter int          ADDR_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] ID_VALUE    = ID_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe
);
   localparam int HALVES = DATA_W / HALF_W;

   if (DATA_W != 32 || HALVES * HALF_W != DATA_W || HALVES != 2) begin : g_bad_width
      $error("mwgpio_bank: DATA_W must be 32, split into two halves of HALF_W");
   end
   if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_addr
      $error("mwgpio_bank: ADDR_W must cover offset 0x78 and fit in 32 bits");
   end

   sel_e sel;
   assign sel = decode_sel(32'(bus_addr));

   logic [HALF_W-1:0] out_q [HALVES];
   logic [HALF_W-1:0] dir_q [HALVES];

   for (genvar g = 0; g < HALVES; g++) begin : g_half
      logic we_out, we_dir;
      assign we_out = bus_wr && (sel == ((g == 0) ? SEL_OUT_LO : SEL_OUT_HI));
      assign we_dir = bus_wr && (sel == ((g == 0) ? SEL_DIR_LO : SEL_DIR_HI));

      mwg_mreg #(.W(HALF_W)) i_out (
         .clk(clk), .rst_n(rst_n), .we(we_out), .wdata(bus_wdata), .q(out_q[g]));
      mwg_mreg #(.W(HALF_W)) i_dir (
         .clk(clk), .rst_n(rst_n), .we(we_dir), .wdata(bus_wdata), .q(dir_q[g]));

      assign pin_out[g*HALF_W +: HALF_W] = out_q[g];
      assign pin_oe[g*HALF_W +: HALF_W]  = dir_q[g];
   end

   logic [DATA_W-1:0] pin_sync;

   mwg_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync));

   mwg_rdmux #(.HALF_W(HALF_W), .ID(ID_VALUE)) i_rdmux (
      .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel),
      .out_lo(out_q[0]), .out_hi(out_q[1]),
      .dir_lo(dir_q[0]), .dir_hi(dir_q[1]),
      .ext(pin_sync), .rdata(bus_rdata));

   // R8: stores outside the four masked registers touch no pin
   p_ignore_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !(sel inside {SEL_OUT_LO, SEL_OUT_HI, SEL_DIR_LO, SEL_DIR_HI})
      |=> $stable(pin_out) && $stable(pin_oe));

   // R2/R3: an output store leaves the direction bits alone
   p_out_keeps_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && (sel inside {SEL_OUT_LO, SEL_OUT_HI}) |=> $stable(pin_oe));

   // R4: a direction store leaves the output levels alone
   p_dir_keeps_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && (sel inside {SEL_DIR_LO, SEL_DIR_HI}) |=> $stable(pin_out));
endmodule

// File: tb/test_mwgpio_bank.sv
module test_mwgpio_bank;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic        bus_wr, bus_rd;
   logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] m_out [2];
   logic [15:0] m_dir [2];
   logic [31:0] m_pins;

   always #(CLK_PERIOD/2) clk = ~clk;

   mwgpio_bank i_mwgpio_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
      return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h00:   return {16'h0, m_out[0]};
         8'h04:   return {16'h0, m_out[1]};
         8'h08:   return {16'h0, m_dir[0]};
         8'h0C:   return {16'h0, m_dir[1]};
         8'h70:   return m_pins;
         8'h78:   return 32'h0101157C;
         default: return 32'h0;
      endcase
   endfunction

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         8'h00: m_out[0] = merge(m_out[0], d);
         8'h04: m_out[1] = merge(m_out[1], d);
         8'h08: m_dir[0] = merge(m_dir[0], d);
         8'h0C: m_dir[1] = merge(m_dir[1], d);
         default: ;
      endcase
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic chk_pins(input string tag);
      chk({tag, " pin_out"}, pin_out, {m_out[1], m_out[0]});
      chk({tag, " pin_oe"}, pin_oe, {m_dir[1], m_dir[0]});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      report();
   end

   initial begin
      logic [31:0] r, old_pins;
      logic [7:0] addrs [8];
      addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h70, 8'h78, 8'h10, 8'h3D};
      void'($urandom(32'd20240601));
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
      bus_wdata = '0; pin_in = '0;
      m_out = '{16'h0, 16'h0}; m_dir = '{16'h0, 16'h0}; m_pins = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 pin_oe", pin_oe, 32'h0);
      chk("R1 rdata", bus_rdata, 32'h0);

      // R2 masked writes on low output register
      wr(8'h00, 32'hFFFF_A5A5); chk_pins("R2 full");
      wr(8'h00, 32'h0001_0000); chk("R2 clear bit0", pin_out, 32'h0000_A5A4);
      wr(8'h00, 32'h0000_FFFF); chk("R2 no enable", pin_out, 32'h0000_A5A4);
      wr(8'h00, 32'h0040_0040); chk("R2 set bit6", pin_out, 32'h0000_A5E4);

      // R3 high output register
      wr(8'h04, 32'h8000_8000); chk("R3 pin31", pin_out, 32'h8000_A5E4);
      wr(8'h04, 32'h0001_0001); chk("R3 pin16", pin_out, 32'h8001_A5E4);

      // R4 direction registers
      wr(8'h08, 32'h00F0_00A0); chk("R4 dir lo", pin_oe, 32'h0000_00A0);
      wr(8'h0C, 32'hFFFF_1234); chk("R4 dir hi", pin_oe, 32'h1234_00A0);
      chk("R4 out untouched", pin_out, 32'h8001_A5E4);

      // R5 read back with zero upper half
      rd(8'h00, r); chk("R5 read out lo", r, 32'h0000_A5E4);
      rd(8'h0C, r); chk("R5 read dir hi", r, 32'h0000_1234);

      // R7 identifier, R10 hold
      rd(8'h78, r); chk("R7 id", r, 32'h0101157C);
      idle(); idle(); chk("R10 hold idle", bus_rdata, 32'h0101157C);
      wr(8'h00, 32'hFFFF_0000); chk("R10 hold over write", bus_rdata, 32'h0101157C);

      // R8 ignored writes
      wr(8'h70, 32'hFFFF_FFFF); chk_pins("R8 ext write");
      wr(8'h78, 32'hFFFF_FFFF); chk_pins("R8 id write");
      wr(8'h10, 32'hFFFF_FFFF); chk_pins("R8 unmapped write");
      wr(8'h01, 32'hFFFF_FFFF); chk_pins("R8 misaligned write");

      // R9 unmapped reads
      rd(8'h10, r); chk("R9 unmapped read", r, 32'h0);
      rd(8'h02, r); chk("R9 misaligned read", r, 32'h0);

      // R6 synchronizer latency: old, old, new
      old_pins = m_pins;
      pin_in = 32'hDEAD_BEEF;
      rd(8'h70, r); chk("R6 edge1 old", r, old_pins);
      rd(8'h70, r); chk("R6 edge2 old", r, old_pins);
      rd(8'h70, r); chk("R6 edge3 new", r, 32'hDEAD_BEEF);
      m_pins = 32'hDEAD_BEEF;

      // random mix
      for (int i = 0; i < 300; i++) begin
         logic [7:0] a;
         if (i % 20 == 0) begin
            pin_in = $urandom;
            m_pins = pin_in;
            idle(); idle();
         end
         a = addrs[$urandom % 8];
         wr(a, $urandom);
         chk_pins("R2/R3/R4/R8 random write");
         rd(a, r);
         chk("R5/R6/R7/R9 random read", r, exp_read(a));
      end

      report();
   end
endmodule